// File: doc/BRIEF.md
# LCD Direct/Duplex Drive Sequencer

This block turns the contents of eight 8-bit segment registers into drive-level codes for a 32-segment liquid crystal panel. It produces one code per backplane and one per segment. Each code is 2 bits wide: `00` is low, `01` is mid (half supply), `10` is high and `11` is high impedance. An external divider supplies a phase tick, and the sequencer takes one phase step per tick.

The block has two drive modes. In direct mode a single backplane alternates between high and low. Each segment is driven either in phase or out of phase with it, and a bank bit chooses whether the even or the odd registers are displayed. In duplex mode the two backplanes take turns: the active one swings high and then low, while the idle one rests at mid. Even registers give the segment states against the first backplane and odd registers give them against the second.

A cascade mode lets several drivers share one set of backplanes. In this mode the block stops driving its backplanes, and it starts each frame only when it sees the rising edge of an external frame-sync signal. Register, mode and bank values are sampled only when a frame starts, so every frame is complete and carries no DC component.

Top module: `lcd_drive_seq`

## Requirements
- R1: From reset until the first frame starts, all segments drive low (00). Both backplanes drive low (00) when `cascade_en` = 0 and are high impedance (11) when `cascade_en` = 1.
- R2: In direct mode (`disp_mode` = 0), a frame has two phases and each accepted `step_tick` advances one phase. The first backplane is high (10) in phase 0 and low (00) in phase 1. The second backplane is high impedance (11).
- R3: In direct mode, a segment whose selected bit is 1 is driven to the opposite level of the first backplane, and a segment whose bit is 0 is driven to the same level.
- R4: Register r occupies `seg_regs[8r+7:8r]`. Segment s (1 to 32) is output on `seg_lvl[2s-1:2s-2]`. In direct mode segment 8k+n+1 takes bit n of register 2k+`bank_sel`, so `bank_sel` = 0 shows registers 0, 2, 4, 6 and `bank_sel` = 1 shows registers 1, 3, 5, 7.
- R5: In duplex mode (`disp_mode` = 1), a frame has four phases: first backplane high, first backplane low, second backplane high, second backplane low. In every phase the backplane that is not active sits at mid (01).
- R6: In duplex mode, segment 8k+n+1 takes bit n of register 2k during the two phases of the first backplane and bit n of register 2k+1 during the two phases of the second backplane. A 1 drives the opposite level of the active backplane and a 0 drives the same level. `bank_sel` has no effect.
- R7: Changes to `seg_regs`, `disp_mode` and `bank_sel` during a frame do not change any output until the next frame starts.
- R8: Count low as 0, mid as 1 and high as 2. Over every complete frame, the difference between each segment and each driven backplane sums to zero.
- R9: When `cascade_en` = 1, both backplanes are high impedance. A frame starts only on a rising edge of `ext_frame_sync`, and such an edge restarts the frame at phase 0 even in the middle of a frame. Ticks advance the phase within the frame but hold it at the last phase.
- R10: A segment output only ever carries the low or the high code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_tick | input | 1 | One-cycle phase-step pulse from the frame divider |
| cascade_en | input | 1 | 1 = backplanes supplied externally, frames aligned to `ext_frame_sync` |
| ext_frame_sync | input | 1 | Observed external backplane; a rising edge marks a frame start |
| disp_mode | input | 1 | 0 = direct drive, 1 = duplex drive |
| bank_sel | input | 1 | Direct mode: 0 shows even registers, 1 shows odd registers |
| seg_regs | input | 64 | Eight segment registers, register r at bits 8r+7..8r |
| bp1_lvl | output | 2 | First backplane level code |
| bp2_lvl | output | 2 | Second backplane level code |
| seg_lvl | output | 64 | Segment level codes, segment s at bits 2s-1..2s-2 |

## Verification
The bench builds the block with its default parameters: four register pairs of eight bits each, which gives the full 32-segment panel. At this size the bench can compare every segment code in every phase of both frame formats against expected values it computes itself. It does this for several register patterns and for both bank settings. Because a whole frame is only two or four ticks long, the bench can check the DC balance of each frame and the hold of sampled values during the frame for every segment. It also steps through the cascade start, hold and realignment cases tick by tick.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_HIZ  = 2'b11
  } lvl_e;

  // Mirror of a two-level drive code.
  function automatic lvl_e lvl_opposite(input lvl_e l);
    return (l == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
  endfunction

  // A lit segment sits opposite its backplane, a dark one follows it.
  function automatic lvl_e seg_drive(input logic lit, input lvl_e bp);
    return lit ? lvl_opposite(bp) : bp;
  endfunction

  // Final phase index of a frame: two phases direct, four duplex.
  function automatic logic [1:0] last_phase(input logic duplex);
    return duplex ? 2'd3 : 2'd1;
  endfunction

  // Selects the odd register of a pair.
  function automatic logic odd_half(input logic duplex, input logic bank,
                                    input logic [1:0] phase);
    return duplex ? phase[1] : bank;
  endfunction

  // Swing level of the active backplane: even phases high, odd low.
  function automatic lvl_e active_level(input logic [1:0] phase);
    return phase[0] ? LVL_LOW : LVL_HIGH;
  endfunction

endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_drv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_tick,
  input  logic       cascade_en,
  input  logic       ext_frame_sync,
  input  logic       duplex_cur,
  output logic [1:0] phase,
  output logic       running,
  output logic       frame_start,
  output logic       ext_rise
);

  logic sync_q;
  logic at_last;
  logic advance;

  assign at_last     = (phase == last_phase(duplex_cur));
  assign ext_rise    = cascade_en & ext_frame_sync & ~sync_q;
  assign frame_start = ext_rise | (~cascade_en & step_tick & (~running | at_last));
  assign advance     = step_tick & running & ~at_last & ~frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      phase   <= 2'd0;
      running <= 1'b0;
    end else begin
      sync_q <= ext_frame_sync;
      if (frame_start) begin
        phase   <= 2'd0;
        running <= 1'b1;
      end else if (advance) begin
        phase <= phase + 2'd1;
      end
    end
  end

  // R7
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (phase == 2'd0) && running);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick && running && !at_last && !frame_start |=> phase == $past(phase) + 2'd1);

  // R2
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick && !ext_rise |=> $stable(phase) && $stable(running));

  // R2
  direct_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !duplex_cur |-> phase <= 2'd1);

  // R9
  cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_en && at_last && !ext_rise |=> $stable(phase));

  // R9
  cascade_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_en && !running && !ext_rise |=> !running);

endmodule

// File: rtl/lcd_shadow_regs.sv
module lcd_shadow_regs #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8,
  localparam int VEC_W   = NUM_REGS * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VEC_W-1:0] regs_in,
  input  logic             duplex_in,
  input  logic             bank_in,
  output logic [VEC_W-1:0] regs_q,
  output logic             duplex_q,
  output logic             bank_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q   <= '0;
      duplex_q <= 1'b0;
      bank_q   <= 1'b0;
    end else if (load) begin
      regs_q   <= regs_in;
      duplex_q <= duplex_in;
      bank_q   <= bank_in;
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(regs_q) && $stable(duplex_q) && $stable(bank_q));

  // R7
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> regs_q == $past(regs_in) && duplex_q == $past(duplex_in));

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_drv_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int REG_W     = 8,
  localparam int NUM_REGS = 2 * NUM_PAIRS,
  localparam int NUM_SEG  = NUM_PAIRS * REG_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      running,
  input  logic                      cascade_en,
  input  logic [1:0]                phase,
  input  logic                      duplex,
  input  logic                      bank,
  input  logic [NUM_REGS*REG_W-1:0] regs,
  output logic [1:0]                bp1_lvl,
  output logic [1:0]                bp2_lvl,
  output logic [NUM_SEG*2-1:0]      seg_lvl
);

  lvl_e swing;
  lvl_e bp1_e;
  lvl_e bp2_e;
  logic use_odd;

  assign swing   = active_level(phase);
  assign use_odd = odd_half(duplex, bank, phase);

  always_comb begin
    if (cascade_en) begin
      bp1_e = LVL_HIZ;
      bp2_e = LVL_HIZ;
    end else if (!running) begin
      bp1_e = LVL_LOW;
      bp2_e = LVL_LOW;
    end else if (!duplex) begin
      bp1_e = swing;
      bp2_e = LVL_HIZ;
    end else begin
      bp1_e = phase[1] ? LVL_MID : swing;
      bp2_e = phase[1] ? swing : LVL_MID;
    end
  end

  assign bp1_lvl = bp1_e;
  assign bp2_lvl = bp2_e;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic [REG_W-1:0] even_b;
    logic [REG_W-1:0] odd_b;
    logic [REG_W-1:0] shown;
    assign even_b = regs[(2*k)*REG_W +: REG_W];
    assign odd_b  = regs[(2*k+1)*REG_W +: REG_W];
    assign shown  = use_odd ? odd_b : even_b;

    for (genvar n = 0; n < REG_W; n++) begin : g_bit
      localparam int SEG_IDX = k * REG_W + n;
      lvl_e drv;
      assign drv = running ? seg_drive(shown[n], swing) : LVL_LOW;
      assign seg_lvl[SEG_IDX*2 +: 2] = drv;

      // R10
      seg_two_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_lvl[SEG_IDX*2]);
    end
  end

  // R1
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> seg_lvl == '0);

  // R5
  duplex_one_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && duplex && !cascade_en |-> (bp1_lvl == 2'b01) != (bp2_lvl == 2'b01));

  // R2
  direct_bp2_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !duplex && !cascade_en |-> bp2_lvl == 2'b11 && bp1_lvl != 2'b01);

  // R9
  cascade_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_en |-> bp1_lvl == 2'b11 && bp2_lvl == 2'b11);

endmodule

// File: rtl/lcd_drive_seq.sv
module lcd_drive_seq #(
  parameter int NUM_PAIRS = 4,
  parameter int REG_W     = 8,
  localparam int NUM_REGS = 2 * NUM_PAIRS,
  localparam int VEC_W    = NUM_REGS * REG_W,
  localparam int NUM_SEG  = NUM_PAIRS * REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_tick,
  input  logic               cascade_en,
  input  logic               ext_frame_sync,
  input  logic               disp_mode,
  input  logic               bank_sel,
  input  logic [VEC_W-1:0]   seg_regs,
  output logic [1:0]         bp1_lvl,
  output logic [1:0]         bp2_lvl,
  output logic [NUM_SEG*2-1:0] seg_lvl
);

  logic [1:0]       phase;
  logic             running;
  logic             frame_start;
  logic             ext_rise;
  logic [VEC_W-1:0] shadow_regs;
  logic             shadow_duplex;
  logic             shadow_bank;

  lcd_phase_seq seq_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .step_tick      (step_tick),
    .cascade_en     (cascade_en),
    .ext_frame_sync (ext_frame_sync),
    .duplex_cur     (shadow_duplex),
    .phase          (phase),
    .running        (running),
    .frame_start    (frame_start),
    .ext_rise       (ext_rise)
  );

  lcd_shadow_regs #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) shadow_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_start),
    .regs_in   (seg_regs),
    .duplex_in (disp_mode),
    .bank_in   (bank_sel),
    .regs_q    (shadow_regs),
    .duplex_q  (shadow_duplex),
    .bank_q    (shadow_bank)
  );

  lcd_level_map #(.NUM_PAIRS(NUM_PAIRS), .REG_W(REG_W)) map_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .cascade_en (cascade_en),
    .phase      (phase),
    .duplex     (shadow_duplex),
    .bank       (shadow_bank),
    .regs       (shadow_regs),
    .bp1_lvl    (bp1_lvl),
    .bp2_lvl    (bp2_lvl),
    .seg_lvl    (seg_lvl)
  );

  // R9
  ext_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> phase == 2'd0 && running);

  // R7
  midframe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(shadow_regs) && $stable(shadow_bank));

endmodule

// File: tb/lcd_drive_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_drive_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_tick = 1'b0;
  logic        cascade_en = 1'b0;
  logic        ext_frame_sync = 1'b0;
  logic        disp_mode = 1'b0;
  logic        bank_sel = 1'b0;
  logic [63:0] seg_regs = '0;
  logic [1:0]  bp1_lvl;
  logic [1:0]  bp2_lvl;
  logic [63:0] seg_lvl;

  int checks = 0;
  int errors = 0;

  // bench view of the design state, built from the requirements
  bit [63:0] sh_regs;
  bit        sh_mode;
  bit        sh_bank;
  bit        run;
  int        ph;
  int        acc1 [32];
  int        acc2 [32];

  always #4 clk = ~clk;

  lcd_drive_seq dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .step_tick      (step_tick),
    .cascade_en     (cascade_en),
    .ext_frame_sync (ext_frame_sync),
    .disp_mode      (disp_mode),
    .bank_sel       (bank_sel),
    .seg_regs       (seg_regs),
    .bp1_lvl        (bp1_lvl),
    .bp2_lvl        (bp2_lvl),
    .seg_lvl        (seg_lvl)
  );

  function automatic int last_of(bit mode);
    return mode ? 3 : 1;
  endfunction

  function automatic bit [1:0] exp_bp(int which);
    bit [1:0] swing;
    swing = (ph % 2 == 0) ? 2'b10 : 2'b00;
    if (cascade_en) return 2'b11;
    if (!run) return 2'b00;
    if (!sh_mode) return (which == 1) ? swing : 2'b11;
    if (which == 1) return (ph < 2) ? swing : 2'b01;
    return (ph >= 2) ? swing : 2'b01;
  endfunction

  function automatic bit [1:0] exp_seg(int j);
    int pair, n, r;
    bit b;
    bit [1:0] swing;
    if (!run) return 2'b00;
    pair  = j / 8;
    n     = j % 8;
    swing = (ph % 2 == 0) ? 2'b10 : 2'b00;
    r     = sh_mode ? (2 * pair + ((ph >= 2) ? 1 : 0)) : (2 * pair + int'(sh_bank));
    b     = sh_regs[r*8 + n];
    if (b) return (swing == 2'b10) ? 2'b00 : 2'b10;
    return swing;
  endfunction

  function automatic bit [63:0] pattern(int p);
    bit [63:0] v;
    case (p)
      0: v = '0;
      1: v = '1;
      2: v = 64'h00FF00FF00FF00FF;
      3: v = 64'hA55AC33C0FF01EE1;
      4: begin
        v = '0;
        for (int r = 0; r < 8; r++) v[r*8 +: 8] = 8'h01 << r;
      end
      default: v = {32'h9E3779B9 * p, 32'h7F4A7C15 ^ p};
    endcase
    return v;
  endfunction

  task automatic chk(string tag);
    bit [63:0] es;
    bit [1:0] e1, e2;
    e1 = exp_bp(1);
    e2 = exp_bp(2);
    for (int j = 0; j < 32; j++) es[j*2 +: 2] = exp_seg(j);
    checks += 4;
    if (bp1_lvl !== e1) begin
      errors++;
      $display("FAIL %s bp1 phase %0d: got %b expected %b", tag, ph, bp1_lvl, e1);
    end
    if (bp2_lvl !== e2) begin
      errors++;
      $display("FAIL %s bp2 phase %0d: got %b expected %b", tag, ph, bp2_lvl, e2);
    end
    if (seg_lvl !== es) begin
      errors++;
      $display("FAIL %s segments phase %0d: got %h expected %h", tag, ph, seg_lvl, es);
    end
    for (int j = 0; j < 32; j++) begin
      if (seg_lvl[j*2 +: 2] != 2'b00 && seg_lvl[j*2 +: 2] != 2'b10) begin
        errors++;
        $display("FAIL R10 segment %0d: got %b expected 00 or 10", j + 1, seg_lvl[j*2 +: 2]);
        break;
      end
    end
  endtask

  task automatic do_reset(bit casc);
    @(negedge clk);
    rst_n = 1'b0;
    cascade_en = casc;
    step_tick = 1'b0;
    ext_frame_sync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 0; ph = 0; sh_regs = '0; sh_mode = 0; sh_bank = 0;
    @(negedge clk);
  endtask

  task automatic latch_live();
    sh_regs = seg_regs;
    sh_mode = disp_mode;
    sh_bank = bank_sel;
    ph = 0;
    run = 1;
  endtask

  task automatic tick();
    @(negedge clk);
    step_tick = 1'b1;
    @(negedge clk);
    step_tick = 1'b0;
    if (cascade_en) begin
      if (run && ph < last_of(sh_mode)) ph++;
    end else if (!run || ph == last_of(sh_mode)) begin
      latch_live();
    end else begin
      ph++;
    end
  endtask

  task automatic ext_pulse();
    @(negedge clk);
    ext_frame_sync = 1'b1;
    @(negedge clk);
    ext_frame_sync = 1'b0;
    latch_live();
  endtask

  task automatic set_live(bit [63:0] r, bit mode, bit bank);
    @(negedge clk);
    seg_regs = r;
    disp_mode = mode;
    bank_sel = bank;
  endtask

  // One full local frame with a mid-frame disturbance of the live inputs.
  task automatic run_frame(bit [63:0] r, bit mode, bit bank, string tag);
    int len;
    bit bad;
    set_live(r, mode, bank);
    tick();
    len = mode ? 4 : 2;
    for (int j = 0; j < 32; j++) begin acc1[j] = 0; acc2[j] = 0; end
    for (int p = 0; p < len; p++) begin
      if (p > 0) tick();
      chk(tag);
      for (int j = 0; j < 32; j++) begin
        acc1[j] += int'(seg_lvl[j*2 +: 2]) - int'(bp1_lvl);
        acc2[j] += int'(seg_lvl[j*2 +: 2]) - int'(bp2_lvl);
      end
      if (p == 0) set_live(~r, ~mode, ~bank);  // R7: must not show until next frame
    end
    checks++;
    bad = 0;
    for (int j = 0; j < 32; j++) begin
      if (!bad && (acc1[j] != 0 || (mode && acc2[j] != 0))) begin
        bad = 1;
        errors++;
        $display("FAIL R8 DC balance segment %0d: got %0d/%0d expected 0/0",
                 j + 1, acc1[j], mode ? acc2[j] : 0);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: local reset state
    do_reset(1'b0);
    chk("R1 reset local");
    repeat (5) @(negedge clk);
    chk("R1 idle without tick");

    // R2 R3 R4 direct bank 0, R4 bank 1, R5 R6 duplex, R6 duplex with bank ignored
    for (int p = 0; p < 7; p++) begin
      run_frame(pattern(p), 1'b0, 1'b0, "R2 R3 R4 R7 direct bank0");
      run_frame(pattern(p), 1'b0, 1'b1, "R3 R4 R7 direct bank1");
      run_frame(pattern(p), 1'b1, 1'b0, "R5 R6 R7 duplex");
      run_frame(pattern(p), 1'b1, 1'b1, "R6 R7 duplex bank ignored");
    end

    // R9: cascade mode
    do_reset(1'b1);
    chk("R1 reset cascade");
    set_live(pattern(3), 1'b1, 1'b0);
    tick();
    tick();
    chk("R9 no start from ticks");
    ext_pulse();
    chk("R9 start on sync edge");
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 duplex phase advance");
    end
    tick();
    chk("R9 hold at last phase");
    tick();
    chk("R9 hold at last phase again");
    ext_pulse();
    tick();
    chk("R9 realigned frame phase 1");
    ext_pulse();
    chk("R9 mid-frame realign to phase 0");
    set_live(pattern(5), 1'b0, 1'b1);
    ext_pulse();
    chk("R9 R4 direct cascade start");
    tick();
    chk("R9 direct cascade phase 1");
    tick();
    chk("R9 direct cascade hold");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule